// File: doc/BRIEF.md
# Parameter Block CRC Engine

This block computes a 16-bit check value over a region of a byte-addressed parameter memory and then stores that value in a fixed two-byte slot of the same memory. A single start strobe supplies the first byte address and the number of bytes to cover. The engine reads the region one byte at a time through a byte-wide read port and combines each pair of bytes into a big-endian 16-bit word. Each word passes through a nibble-folded update step. When every word has been folded in, the result goes out through a byte-wide write port, high byte first.

The read port is asynchronous. The engine drives `rd_en` and `rd_addr`, and the memory returns `rd_data` in the same cycle. A word costs three cycles: read high, read low, update. A trailing odd byte costs two cycles: read high, update. The state machine has seven states:

- IDLE
- RD_HI
- RD_LO
- UPDATE
- WR_HI
- WR_LO
- DONE

Its transitions are:

- **IDLE→RD_HI**: start with a non-zero count.
- **IDLE→WR_HI**: start with a zero count.
- **RD_HI→RD_LO**: more than one byte left.
- **RD_HI→UPDATE**: one byte left, so the low byte is padded.
- **RD_LO→UPDATE**: always.
- **UPDATE→RD_HI**: bytes remain.
- **UPDATE→WR_HI**: no bytes remain.
- **WR_HI→WR_LO**: always.
- **WR_LO→DONE**: always.
- **DONE→IDLE**: no start.
- **DONE→RD_HI / WR_HI**: a new start, as from IDLE.

Top module: `pbcrc_engine`

## Requirements
- R1: A start strobe is accepted only in a cycle where busy is low (state IDLE or DONE). Accepting it loads the check register with 0xFFFF, the address with start_addr and the remaining count with byte_count. A start while busy is high has no effect on the reads, writes or result of the run in progress.
- R2: Each word is read as two consecutive read cycles. The byte at address a is read first and becomes bits 15:8. The byte at a+1 is read next and becomes bits 7:0. rd_data is taken in the same cycle that rd_en is high. One UPDATE cycle follows each word, during which neither port is active.
- R3: When the remaining count is one at a high-byte read, that byte forms bits 15:8 of the word and bits 7:0 are zero. No low-byte read takes place for it.
- R4: The update step works on the previous value p and the word w, all in 16 bits:
  - t = p >> 8
  - d = p ^ w
  - n1 = d & 0xF
  - n2 = ((d >> 4) & 0xF) ^ n1
  - result = t ^ (n1 << 3) ^ (n1 << 8) ^ n2 ^ (n2 << 7) ^ (n2 << 12)

  For p = 0xFFFF and w = 0x0000 the result is 0x0F87.
- R5: After the last update, the result is written in two consecutive write cycles. Bits 15:8 go to SLOT_ADDR and bits 7:0 go to SLOT_ADDR+1. No read happens in the same cycle as a write.
- R6: A byte count of zero performs no reads and writes 0xFFFF to the slot.
- R7: busy is high from the cycle after an accepted start through the cycle of the low-byte write. done is high for exactly the one cycle after that, with busy low.
- R8: While and after reset, with no start, busy, done, rd_en and wr_en are all low.
- R9: Over the standard region of bytes 0x00 to 0xF7 (count 0xF8), the value written to 0xFC/0xFD equals the result of R4 applied word by word from the seed 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, one cycle |
| start_addr | input | ADDR_W | First byte address of the region |
| byte_count | input | CNT_W | Number of bytes in the region |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_data | input | 8 | Read data, valid in the same cycle as rd_en |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with ADDR_W = 8, CNT_W = 9 and SLOT_ADDR = 0xFC, so that a 256-byte array models the whole address space. With that space, the bench can run:

- the standard 0xF8-byte region;
- a region that covers the check slot itself;
- counts of zero, one and other odd values.

A behavioural model predicts, cycle by cycle, every read address, write and flag, and it is compared against the ports on every clock. A start pulsed in the middle of a run shows that the run completes undisturbed.

// File: rtl/pbcrc_pkg.sv
package pbcrc_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_HI  = 3'd1,
        ST_RD_LO  = 3'd2,
        ST_UPDATE = 3'd3,
        ST_WR_HI  = 3'd4,
        ST_WR_LO  = 3'd5,
        ST_DONE   = 3'd6
    } pbcrc_state_e;

endpackage

// File: rtl/pbcrc_step.sv
// Nibble-folded update of the 16-bit check value with one big-endian word.
module pbcrc_step
    import pbcrc_pkg::*;
(
    input  logic [CRC_W-1:0] prev_val,
    input  logic [CRC_W-1:0] word_in,
    output logic [CRC_W-1:0] next_val
);
    logic [CRC_W-1:0] mix;
    logic [CRC_W-1:0] n_lo;
    logic [CRC_W-1:0] n_fold;
    logic [CRC_W-1:0] acc;

    always_comb begin
        mix    = prev_val ^ word_in;
        n_lo   = {12'd0, mix[3:0]};
        n_fold = {12'd0, mix[7:4] ^ mix[3:0]};
        acc    = prev_val >> 8;
        acc    = acc ^ (n_lo << 3) ^ (n_lo << 8);
        acc    = acc ^ n_fold ^ (n_fold << 7) ^ (n_fold << 12);
        next_val = acc;
    end
endmodule

// File: rtl/pbcrc_fsm.sv
// Sequencer: state register, next-state logic and decoded controls.
module pbcrc_fsm
    import pbcrc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cnt_zero,
    input  logic         rem_one,
    input  logic         rem_zero,
    output pbcrc_state_e state_q,
    output logic         load,
    output logic         rd_en,
    output logic         wr_en,
    output logic         wr_low,
    output logic         busy,
    output logic         done
);
    pbcrc_state_e state_d;
    logic         idle_like;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = cnt_zero ? ST_WR_HI : ST_RD_HI;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_HI:  state_d = rem_one ? ST_UPDATE : ST_RD_LO;
            ST_RD_LO:  state_d = ST_UPDATE;
            ST_UPDATE: state_d = rem_zero ? ST_WR_HI : ST_RD_HI;
            ST_WR_HI:  state_d = ST_WR_LO;
            ST_WR_LO:  state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load   = 1'b0;
        rd_en  = 1'b0;
        wr_en  = 1'b0;
        wr_low = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            ST_RD_HI, ST_RD_LO: begin
                rd_en = 1'b1;
                busy  = 1'b1;
            end
            ST_UPDATE: busy = 1'b1;
            ST_WR_HI: begin
                wr_en = 1'b1;
                busy  = 1'b1;
            end
            ST_WR_LO: begin
                wr_en  = 1'b1;
                wr_low = 1'b1;
                busy   = 1'b1;
            end
            default: ;
        endcase
        if (!idle_like) load = 1'b0;
    end
endmodule

// File: rtl/pbcrc_dpath.sv
// Address walk, remaining count, word assembly and check register.
module pbcrc_dpath
    import pbcrc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          CNT_W     = 16,
    parameter int unsigned SLOT_ADDR = 'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pbcrc_state_e      state_q,
    input  logic              load,
    input  logic              wr_low,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              cnt_zero,
    output logic              rem_one,
    output logic              rem_zero
);
    localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'(SLOT_ADDR);
    localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'(SLOT_ADDR + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [7:0]        hi_q;
    logic [7:0]        lo_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_next;

    pbcrc_step u_step (
        .prev_val (crc_q),
        .word_in  ({hi_q, lo_q}),
        .next_val (crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            crc_q  <= CRC_SEED;
        end else if (load) begin
            addr_q <= start_addr;
            rem_q  <= byte_count;
            crc_q  <= CRC_SEED;
        end else begin
            unique case (state_q)
                ST_RD_HI: begin
                    hi_q   <= rd_data;
                    lo_q   <= 8'h00;
                    addr_q <= addr_q + ADDR_W'(1);
                    rem_q  <= rem_q - CNT_W'(1);
                end
                ST_RD_LO: begin
                    lo_q   <= rd_data;
                    addr_q <= addr_q + ADDR_W'(1);
                    rem_q  <= rem_q - CNT_W'(1);
                end
                ST_UPDATE: crc_q <= crc_next;
                default: ;
            endcase
        end
    end

    assign cnt_zero = (byte_count == '0);
    assign rem_one  = (rem_q == CNT_W'(1));
    assign rem_zero = (rem_q == '0);
    assign rd_addr  = addr_q;
    assign wr_addr  = wr_low ? SLOT_LO : SLOT_HI;
    assign wr_data  = wr_low ? crc_q[7:0] : crc_q[15:8];
endmodule

// File: rtl/pbcrc_engine.sv
module pbcrc_engine
    import pbcrc_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          CNT_W     = 16,
    parameter int unsigned SLOT_ADDR = 'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done
);
    pbcrc_state_e state_q;
    logic         load;
    logic         wr_low;
    logic         cnt_zero;
    logic         rem_one;
    logic         rem_zero;

    pbcrc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cnt_zero (cnt_zero),
        .rem_one  (rem_one),
        .rem_zero (rem_zero),
        .state_q  (state_q),
        .load     (load),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wr_low   (wr_low),
        .busy     (busy),
        .done     (done)
    );

    pbcrc_dpath #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .SLOT_ADDR (SLOT_ADDR)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .load       (load),
        .wr_low     (wr_low),
        .start_addr (start_addr),
        .byte_count (byte_count),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cnt_zero   (cnt_zero),
        .rem_one    (rem_one),
        .rem_zero   (rem_zero)
    );
endmodule

// File: rtl/pbcrc_engine_chk.sv
module pbcrc_engine_chk #(
    parameter int          ADDR_W    = 16,
    parameter int unsigned SLOT_ADDR = 'hFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'(SLOT_ADDR);
    localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'(SLOT_ADDR + 1);

    AST_NO_RD_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R5
    AST_WR_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SLOT_HI) |=> (wr_en && wr_addr == SLOT_LO)); // R5
    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy); // R2
    AST_RD_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1))); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(wr_en) && $past(wr_addr) == SLOT_LO)); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R1
endmodule

bind pbcrc_engine pbcrc_engine_chk #(
    .ADDR_W    (ADDR_W),
    .SLOT_ADDR (SLOT_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .busy    (busy),
    .done    (done)
);

// File: tb/pbcrc_engine_tb.sv
module pbcrc_engine_tb_top;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 9;
    localparam int SLOT   = 'hFC;

    typedef struct {
        bit       busy;
        bit       done;
        bit       rd_en;
        int       rd_addr;
        bit       wr_en;
        int       wr_addr;
        int       wr_data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  byte_count = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              busy;
    logic              done;

    logic [7:0] mem [256];
    exp_t       q[$];
    exp_t       cur;
    int         compared = 0;
    int         mismatched = 0;
    int         cycles = 0;
    int         last_crc = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    pbcrc_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOT_ADDR(SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
    );

    assign rd_data = mem[rd_addr];

    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    function automatic int ref_step(int p, int w);
        int t, d, a, b;
        t = (p >> 8) & 16'hFFFF;
        d = (p ^ w) & 16'hFFFF;
        a = d & 15;
        b = ((d >> 4) & 15) ^ a;
        t = t ^ (a << 3) ^ (a << 8);
        t = t ^ b ^ (b << 7) ^ (b << 12);
        return t & 16'hFFFF;
    endfunction

    function automatic exp_t mk(bit bz, bit dn, bit re, int ra, bit we, int wa, int wd);
        exp_t e;
        e.busy = bz; e.done = dn; e.rd_en = re; e.rd_addr = ra;
        e.wr_en = we; e.wr_addr = wa; e.wr_data = wd;
        return e;
    endfunction

    // Behavioural plan of a whole run, pushed one entry per expected cycle.
    task automatic plan_run(int a0, int n0);
        int crc = 16'hFFFF;
        int a = a0;
        int n = n0;
        while (n > 0) begin
            int hi, lo;
            hi = mem[a & 255];
            q.push_back(mk(1, 0, 1, a & 255, 0, 0, 0));
            a++; n--;
            if (n > 0) begin
                lo = mem[a & 255];
                q.push_back(mk(1, 0, 1, a & 255, 0, 0, 0));
                a++; n--;
            end else begin
                lo = 0;
            end
            crc = ref_step(crc, (hi << 8) | lo);
            q.push_back(mk(1, 0, 0, 0, 0, 0, 0));
        end
        q.push_back(mk(1, 0, 0, 0, 1, SLOT, (crc >> 8) & 255));
        q.push_back(mk(1, 0, 0, 0, 1, SLOT + 1, crc & 255));
        q.push_back(mk(0, 1, 0, 0, 0, 0, 0));
        last_crc = crc;
    endtask

    // Model advance at every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = mk(0, 0, 0, 0, 0, 0, 0);
        end else begin
            bit accept;
            accept = start && !cur.busy;
            if (q.size() > 0) void'(q.pop_front());
            if (accept) plan_run(int'(start_addr), int'(byte_count));
            cur = (q.size() > 0) ? q[0] : mk(0, 0, 0, 0, 0, 0, 0);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk("R8", "busy in reset", int'(busy), 0);
                chk("R8", "done in reset", int'(done), 0);
                chk("R8", "rd_en in reset", int'(rd_en), 0);
                chk("R8", "wr_en in reset", int'(wr_en), 0);
            end else begin
                chk("R7", "busy", int'(busy), int'(cur.busy));
                chk("R7", "done", int'(done), int'(cur.done));
                chk("R2", "rd_en", int'(rd_en), int'(cur.rd_en));
                if (cur.rd_en) chk("R2", "rd_addr", int'(rd_addr), cur.rd_addr);
                chk("R5", "wr_en", int'(wr_en), int'(cur.wr_en));
                if (cur.wr_en) begin
                    chk("R5", "wr_addr", int'(wr_addr), cur.wr_addr);
                    chk("R5", "wr_data", int'(wr_data), cur.wr_data);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic pulse_start(int a, int n);
        @(negedge clk);
        start = 1'b1;
        start_addr = ADDR_W'(a);
        byte_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic check_slot(string req, int exp);
        @(negedge clk);
        chk(req, "slot value", (int'(mem[SLOT]) << 8) | int'(mem[SLOT + 1]), exp);
    endtask

    initial begin
        int saved;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R6: zero count writes the seed
        pulse_start(8'h20, 0);
        wait_idle();
        check_slot("R6", 16'hFFFF);

        // R4: known answer for one all-zero word
        mem[8'h60] = 8'h00;
        mem[8'h61] = 8'h00;
        pulse_start(8'h60, 2);
        wait_idle();
        check_slot("R4", 16'h0F87);

        // R3: single byte, padded low byte
        pulse_start(8'h33, 1);
        wait_idle();
        check_slot("R3", last_crc);

        // R3: odd count of five
        pulse_start(8'h41, 5);
        wait_idle();
        check_slot("R3", last_crc);

        // R9: standard region
        pulse_start(8'h00, 8'hF8);
        wait_idle();
        check_slot("R9", last_crc);

        // R4: region covering the slot itself
        pulse_start(8'hF0, 16);
        wait_idle();
        check_slot("R4", last_crc);

        // R1: start while busy is ignored
        pulse_start(8'h10, 8);
        saved = last_crc;
        repeat (4) @(posedge clk);
        pulse_start(8'h80, 3);
        wait_idle();
        check_slot("R1", saved);
        chk("R1", "planned result unchanged", last_crc, saved);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule